// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the mode-control state machine of a CAN protocol controller. It takes the controller off the bus in two ways. Freeze is a debug halt in which the error counters can be written. Low-power stop turns off the internal clock while the register side keeps running. Entry to either mode uses a handshake: the sequencer waits for the right bus and activity conditions, and only then does it raise its acknowledge. After any exit, the sequencer listens for a run of consecutive recessive bits before it lets the frame engine take part in traffic again.

The states are RESYNC, ACTIVE, FRZ_WAIT, FROZEN, STP_BUS, STP_CORE and STOPPED. The transitions are as follows:

- Reset and soft reset go to RESYNC.
- RESYNC goes to ACTIVE when the recessive run completes.
- RESYNC and ACTIVE go to FRZ_WAIT on a freeze request, or to STP_BUS on a stop request.
- FRZ_WAIT goes to FROZEN when all activity is idle.
- FROZEN goes to RESYNC when the request is dropped.
- STP_BUS goes to STP_CORE on an idle bus or a recessive third intermission bit.
- STP_CORE goes to STOPPED when the core is idle.
- STOPPED goes to RESYNC when stop is cleared, or on a self-wake edge.
- A wait state that loses its request aborts. It goes to ACTIVE if the block was synchronized, and to RESYNC otherwise.
- A freeze request moves STP_BUS or STP_CORE to FRZ_WAIT.

A sticky wake flag records bus edges seen while stopped. It drives an interrupt when the interrupt is unmasked.

Top module: `can_mode_seq`

## Requirements
- R1: The freeze request is `frz_line_i | halt_i`. Taken in RESYNC or ACTIVE, it leads to a wait state. `frz_ack_o` rises at the first later clock edge at which `busy_all_i` is low. If the request drops during the wait, the block returns to ACTIVE when `not_ready_o` was low, and to RESYNC otherwise.
- R2: While frozen, the outputs are: `presc_en_o`=0, `rx_ignore_o`=1, `tx_rec_o`=1, `not_ready_o`=1 and `clk_en_o`=1.
- R3: `ecnt_wr_ok_o` is high exactly while `frz_ack_o` is high.
- R4: The frozen state is left at the first edge with no freeze request. `frz_ack_o` falls at that edge while `not_ready_o` stays 1.
- R5: After reset, and after leaving freeze or stop, `not_ready_o` and `tx_rec_o` are 1. They fall at the edge of the RESYNC_BITS-th (default 11) consecutive `bit_tick_i` sample with `rx_i`=1 (recessive). A tick with `rx_i`=0 restarts the count from zero.
- R6: A stop request (`stop_i`=1 with no freeze request) waits for `bus_idle_i | gap3_rec_i`, then waits at a later edge for `busy_core_i`=0. Each wait lasts at least one cycle. `stop_ack_o` rises when both waits are over.
- R7: While stopped, the outputs are: `clk_en_o`=0, `presc_en_o`=0, `rx_ignore_o`=1, `tx_rec_o`=1, `not_ready_o`=1 and `stop_ack_o`=1.
- R8: Stop is left for RESYNC when `stop_i` is 0. If `selfwake_i` was 1 at the entry edge, a falling edge on `rx_i` also leaves stop; a falling edge means `rx_i`=0 after 1 on the previous cycle. `stop_clr_o` pulses for one cycle after such a self-wake. Without self-wake, the block stays stopped.
- R9: A falling `rx_i` edge while stopped sets `wake_flag_o`, whether or not self-wake is armed. The flag stays set until `wake_clr_i` is 1 at a clock edge with no new edge.
- R10: `irq_o` equals `wake_flag_o & wakemsk_i` in the same cycle.
- R11: `softrst_i`=1 at a clock edge acts like reset. The state goes to RESYNC, `not_ready_o` goes to 1, and the wake flag and self-wake arming are cleared.
- R12: Freeze wins over stop when both are requested together. A freeze request during either stop wait state moves the block to the freeze wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (ungated register-side clock) |
| rst_n | input | 1 | Asynchronous reset, active low |
| softrst_i | input | 1 | Synchronous soft reset control bit |
| frz_line_i | input | 1 | External freeze request line |
| halt_i | input | 1 | Software halt control bit |
| stop_i | input | 1 | Low-power stop control bit |
| selfwake_i | input | 1 | Enables wake-up on a bus edge, sampled at stop entry |
| wakemsk_i | input | 1 | Wake interrupt enable |
| wake_clr_i | input | 1 | Write-one-to-clear strobe for the wake flag |
| busy_all_i | input | 1 | Any internal activity in progress |
| busy_core_i | input | 1 | Activity outside the bus interface in progress |
| bus_idle_i | input | 1 | Bus is idle |
| gap3_rec_i | input | 1 | Third intermission bit sampled recessive |
| rx_i | input | 1 | Sampled receive bit, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| presc_en_o | output | 1 | Prescaler enable |
| clk_en_o | output | 1 | Clock gate enable for internal logic |
| tx_rec_o | output | 1 | Force transmit recessive |
| rx_ignore_o | output | 1 | Receive input ignored |
| not_ready_o | output | 1 | Not synchronized to the bus |
| frz_ack_o | output | 1 | Freeze acknowledge |
| stop_ack_o | output | 1 | Stop acknowledge |
| wake_flag_o | output | 1 | Sticky wake event flag |
| irq_o | output | 1 | Wake interrupt request |
| ecnt_wr_ok_o | output | 1 | Error counter write permission |
| stop_clr_o | output | 1 | One-cycle pulse that clears the stop control bit |

## Verification
The assertions assume that `rx_i` and the status inputs are synchronous and held for whole cycles. They also assume that `bit_tick_i` is a single-cycle strobe, and that the busy flags eventually fall, so that a wait state can end. The stimulus changes every input only at the falling clock edge and generates the tick as a regular pulse every fourth cycle. It holds `rx_i` recessive for as long as a resynchronization run has to complete. It produces a falling receive edge only after at least one recessive cycle, so the edge-based checks on the wake flag always see a real transition.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        MS_RESYNC   = 3'd0,
        MS_ACTIVE   = 3'd1,
        MS_FRZ_WAIT = 3'd2,
        MS_FROZEN   = 3'd3,
        MS_STP_BUS  = 3'd4,
        MS_STP_CORE = 3'd5,
        MS_STOPPED  = 3'd6
    } mode_e;

endpackage

// File: rtl/cms_resync_cnt.sv
// Counts consecutive recessive bit samples; done fires on the sample that completes the run.
module cms_resync_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr_i) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (!rx_i) begin
                run_q <= '0;
            end else if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    assign done_o = tick_i && rx_i && (run_q == LAST);

endmodule

// File: rtl/cms_wake_unit.sv
// Detects recessive-to-dominant edges on the receive bit and keeps the sticky wake flag.
module cms_wake_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_i,
    input  logic stopped_i,
    input  logic clr_i,
    input  logic rx_i,
    output logic edge_o,
    output logic flag_o
);
    logic rx_prev_q;
    logic flag_q;

    assign edge_o = stopped_i && rx_prev_q && !rx_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_prev_q <= 1'b1;
            flag_q    <= 1'b0;
        end else begin
            rx_prev_q <= rx_i;
            if (srst_i) begin
                flag_q <= 1'b0;
            end else if (edge_o) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int RESYNC_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic softrst_i,
    input  logic frz_line_i,
    input  logic halt_i,
    input  logic stop_i,
    input  logic selfwake_i,
    input  logic wakemsk_i,
    input  logic wake_clr_i,
    input  logic busy_all_i,
    input  logic busy_core_i,
    input  logic bus_idle_i,
    input  logic gap3_rec_i,
    input  logic rx_i,
    input  logic bit_tick_i,
    output logic presc_en_o,
    output logic clk_en_o,
    output logic tx_rec_o,
    output logic rx_ignore_o,
    output logic not_ready_o,
    output logic frz_ack_o,
    output logic stop_ack_o,
    output logic wake_flag_o,
    output logic irq_o,
    output logic ecnt_wr_ok_o,
    output logic stop_clr_o
);

    mode_e mode_q, mode_d;
    logic  nr_q, nr_d;
    logic  arm_q;
    logic  sclr_q, sclr_d;
    logic  frz_req;
    logic  run_done;
    logic  wake_edge;
    logic  abort_ok;
    mode_e abort_to;

    assign frz_req  = frz_line_i | halt_i;
    assign abort_to = nr_q ? MS_RESYNC : MS_ACTIVE;

    cms_resync_cnt #(
        .RUN_LEN (RESYNC_BITS)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (softrst_i || (mode_q != MS_RESYNC)),
        .tick_i (bit_tick_i),
        .rx_i   (rx_i),
        .done_o (run_done)
    );

    cms_wake_unit u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (softrst_i),
        .stopped_i (mode_q == MS_STOPPED),
        .clr_i     (wake_clr_i),
        .rx_i      (rx_i),
        .edge_o    (wake_edge),
        .flag_o    (wake_flag_o)
    );

    // next-state selection
    always_comb begin
        mode_d   = mode_q;
        sclr_d   = 1'b0;
        abort_ok = 1'b0;
        if (softrst_i) begin
            mode_d = MS_RESYNC;
        end else begin
            unique case (mode_q)
                MS_RESYNC: begin
                    if (frz_req)       mode_d = MS_FRZ_WAIT;
                    else if (stop_i)   mode_d = MS_STP_BUS;
                    else if (run_done) mode_d = MS_ACTIVE;
                end
                MS_ACTIVE: begin
                    if (frz_req)       mode_d = MS_FRZ_WAIT;
                    else if (stop_i)   mode_d = MS_STP_BUS;
                end
                MS_FRZ_WAIT: begin
                    if (!frz_req) begin
                        mode_d   = abort_to;
                        abort_ok = 1'b1;
                    end else if (!busy_all_i) begin
                        mode_d = MS_FROZEN;
                    end
                end
                MS_FROZEN: begin
                    if (!frz_req)      mode_d = MS_RESYNC;
                end
                MS_STP_BUS: begin
                    if (frz_req) begin
                        mode_d = MS_FRZ_WAIT;
                    end else if (!stop_i) begin
                        mode_d   = abort_to;
                        abort_ok = 1'b1;
                    end else if (bus_idle_i || gap3_rec_i) begin
                        mode_d = MS_STP_CORE;
                    end
                end
                MS_STP_CORE: begin
                    if (frz_req) begin
                        mode_d = MS_FRZ_WAIT;
                    end else if (!stop_i) begin
                        mode_d   = abort_to;
                        abort_ok = 1'b1;
                    end else if (!busy_core_i) begin
                        mode_d = MS_STOPPED;
                    end
                end
                MS_STOPPED: begin
                    if (wake_edge && arm_q) begin
                        mode_d = MS_RESYNC;
                        sclr_d = 1'b1;
                    end else if (!stop_i) begin
                        mode_d = MS_RESYNC;
                    end
                end
                default: mode_d = MS_RESYNC;
            endcase
        end
    end

    // not-ready tracks synchronization across the wait states
    always_comb begin
        nr_d = nr_q;
        unique case (mode_d)
            MS_ACTIVE:                           nr_d = 1'b0;
            MS_RESYNC, MS_FROZEN, MS_STOPPED:    nr_d = 1'b1;
            MS_FRZ_WAIT, MS_STP_BUS, MS_STP_CORE: nr_d = abort_ok ? 1'b0 : nr_q;
            default:                             nr_d = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MS_RESYNC;
            nr_q   <= 1'b1;
            arm_q  <= 1'b0;
            sclr_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            nr_q   <= nr_d;
            sclr_q <= sclr_d;
            if (softrst_i) begin
                arm_q <= 1'b0;
            end else if (mode_d == MS_STOPPED && mode_q != MS_STOPPED) begin
                arm_q <= selfwake_i;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        presc_en_o   = 1'b1;
        clk_en_o     = 1'b1;
        rx_ignore_o  = 1'b0;
        frz_ack_o    = 1'b0;
        stop_ack_o   = 1'b0;
        ecnt_wr_ok_o = 1'b0;
        unique case (mode_q)
            MS_FROZEN: begin
                presc_en_o   = 1'b0;
                rx_ignore_o  = 1'b1;
                frz_ack_o    = 1'b1;
                ecnt_wr_ok_o = 1'b1;
            end
            MS_STOPPED: begin
                presc_en_o   = 1'b0;
                clk_en_o     = 1'b0;
                rx_ignore_o  = 1'b1;
                stop_ack_o   = 1'b1;
            end
            MS_RESYNC, MS_ACTIVE, MS_FRZ_WAIT, MS_STP_BUS, MS_STP_CORE: begin
                presc_en_o = 1'b1;
            end
            default: begin
                presc_en_o = 1'b1;
            end
        endcase
    end

    assign tx_rec_o    = nr_q;
    assign not_ready_o = nr_q;
    assign stop_clr_o  = sclr_q;
    assign irq_o       = wake_flag_o & wakemsk_i;

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic softrst_i,
    input logic busy_all_i,
    input logic busy_core_i,
    input logic wake_clr_i,
    input logic rx_i,
    input logic bit_tick_i,
    input logic presc_en_o,
    input logic clk_en_o,
    input logic tx_rec_o,
    input logic rx_ignore_o,
    input logic not_ready_o,
    input logic frz_ack_o,
    input logic stop_ack_o,
    input logic wake_flag_o,
    input logic stop_clr_o
);

    p_wait_idle_r1: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        $rose(frz_ack_o) |-> $past(!busy_all_i));

    p_frozen_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        frz_ack_o |-> (!presc_en_o && rx_ignore_o && tx_rec_o && not_ready_o && clk_en_o));

    p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        $fell(not_ready_o) |-> ($past(bit_tick_i && rx_i) || !$past(frz_ack_o || stop_ack_o)));

    p_core_idle_r6: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        $rose(stop_ack_o) |-> $past(!busy_core_i));

    p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        stop_ack_o |-> (!clk_en_o && !presc_en_o && rx_ignore_o && tx_rec_o));

    p_selfwake_exit_r8: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        stop_clr_o |-> (!stop_ack_o && not_ready_o && $past(stop_ack_o)));

    p_wake_source_r9: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        $rose(wake_flag_o) |-> ($past(stop_ack_o) && $past(!rx_i)));

    p_wake_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || softrst_i)
        (wake_flag_o && !wake_clr_i) |=> wake_flag_o);

endmodule

bind can_mode_seq can_mode_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .softrst_i   (softrst_i),
    .busy_all_i  (busy_all_i),
    .busy_core_i (busy_core_i),
    .wake_clr_i  (wake_clr_i),
    .rx_i        (rx_i),
    .bit_tick_i  (bit_tick_i),
    .presc_en_o  (presc_en_o),
    .clk_en_o    (clk_en_o),
    .tx_rec_o    (tx_rec_o),
    .rx_ignore_o (rx_ignore_o),
    .not_ready_o (not_ready_o),
    .frz_ack_o   (frz_ack_o),
    .stop_ack_o  (stop_ack_o),
    .wake_flag_o (wake_flag_o),
    .stop_clr_o  (stop_clr_o)
);

// File: tb/can_mode_seq_tb_top.sv
module can_mode_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RUN        = 11;
    localparam int TICK_DIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic softrst = 0, frz_line = 0, halt = 0, stop = 0, selfwake = 0, wakemsk = 0;
    logic wake_clr = 0, busy_all = 0, busy_core = 0, bus_idle = 0, gap3 = 0;
    logic rx = 1, tick = 0;
    logic presc_en, clk_en, tx_rec, rx_ign, not_ready, frz_ack, stop_ack;
    logic wake_flag, irq, ecnt_ok, stop_clr;

    int n_chk = 0;
    int n_bad = 0;
    int tcnt  = 0;

    // behavioural reference: mode names as strings
    string m_mode;
    bit    m_nr, m_arm, m_flag, m_rxp, m_sclr;
    int    m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_seq #(.RESYNC_BITS(RUN)) dut_i (
        .clk(clk), .rst_n(rst_n), .softrst_i(softrst), .frz_line_i(frz_line),
        .halt_i(halt), .stop_i(stop), .selfwake_i(selfwake), .wakemsk_i(wakemsk),
        .wake_clr_i(wake_clr), .busy_all_i(busy_all), .busy_core_i(busy_core),
        .bus_idle_i(bus_idle), .gap3_rec_i(gap3), .rx_i(rx), .bit_tick_i(tick),
        .presc_en_o(presc_en), .clk_en_o(clk_en), .tx_rec_o(tx_rec),
        .rx_ignore_o(rx_ign), .not_ready_o(not_ready), .frz_ack_o(frz_ack),
        .stop_ack_o(stop_ack), .wake_flag_o(wake_flag), .irq_o(irq),
        .ecnt_wr_ok_o(ecnt_ok), .stop_clr_o(stop_clr)
    );

    task automatic model_step();
        bit    req  = frz_line | halt;
        bit    edg  = (m_mode == "STOPPED") && m_rxp && !rx;
        string nxt  = m_mode;
        bit    sync = !m_nr;
        bit    abrt = 0;
        m_sclr = 0;
        if (softrst) nxt = "RESYNC";
        else if (m_mode == "RESYNC") begin
            if (req) nxt = "FWAIT";
            else if (stop) nxt = "SBUS";
            else if (tick && rx && m_run == RUN - 1) nxt = "ACTIVE";
        end else if (m_mode == "ACTIVE") begin
            if (req) nxt = "FWAIT";
            else if (stop) nxt = "SBUS";
        end else if (m_mode == "FWAIT") begin
            if (!req) begin nxt = sync ? "ACTIVE" : "RESYNC"; abrt = 1; end
            else if (!busy_all) nxt = "FROZEN";
        end else if (m_mode == "FROZEN") begin
            if (!req) nxt = "RESYNC";
        end else if (m_mode == "SBUS" || m_mode == "SCORE") begin
            if (req) nxt = "FWAIT";
            else if (!stop) begin nxt = sync ? "ACTIVE" : "RESYNC"; abrt = 1; end
            else if (m_mode == "SBUS" && (bus_idle || gap3)) nxt = "SCORE";
            else if (m_mode == "SCORE" && !busy_core) nxt = "STOPPED";
        end else if (m_mode == "STOPPED") begin
            if (edg && m_arm) begin nxt = "RESYNC"; m_sclr = 1; end
            else if (!stop) nxt = "RESYNC";
        end
        // recessive run counter
        if (softrst || m_mode != "RESYNC") m_run = 0;
        else if (tick) m_run = rx ? ((m_run == RUN - 1) ? 0 : m_run + 1) : 0;
        // wake flag
        if (softrst) m_flag = 0;
        else if (edg) m_flag = 1;
        else if (wake_clr) m_flag = 0;
        // arming
        if (softrst) m_arm = 0;
        else if (nxt == "STOPPED" && m_mode != "STOPPED") m_arm = selfwake;
        // sync status
        if (nxt == "ACTIVE") m_nr = 0;
        else if (nxt == "RESYNC" || nxt == "FROZEN" || nxt == "STOPPED") m_nr = 1;
        if (abrt && nxt == "ACTIVE") m_nr = 0;
        m_rxp  = rx;
        m_mode = nxt;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = "RESYNC"; m_nr = 1; m_arm = 0; m_flag = 0; m_rxp = 1; m_sclr = 0; m_run = 0;
        end else begin
            model_step();
        end
    end

    task automatic check1(string tag, string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit fz = (m_mode == "FROZEN");
        bit st = (m_mode == "STOPPED");
        check1("R2", "presc_en",  presc_en,  !(fz || st));
        check1("R7", "clk_en",    clk_en,    !st);
        check1("R5", "tx_rec",    tx_rec,    m_nr);
        check1("R2", "rx_ignore", rx_ign,    fz || st);
        check1("R5", "not_ready", not_ready, m_nr);
        check1("R1", "frz_ack",   frz_ack,   fz);
        check1("R6", "stop_ack",  stop_ack,  st);
        check1("R9", "wake_flag", wake_flag, m_flag);
        check1("R10", "irq",      irq,       m_flag && wakemsk);
        check1("R3", "ecnt_ok",   ecnt_ok,   fz);
        check1("R8", "stop_clr",  stop_clr,  m_sclr);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            tcnt++;
            tick = (tcnt % TICK_DIV == 0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check1("R5", "reset not_ready", not_ready, 1'b1);
        check1("R5", "reset tx_rec", tx_rec, 1'b1);
        check1("R1", "reset frz_ack", frz_ack, 1'b0);
        check1("R6", "reset stop_ack", stop_ack, 1'b0);
        rst_n = 1;
        step(60);
        check1("R5", "synced after run", not_ready, 1'b0);

        // R1: freeze waits for idle activity
        busy_all = 1; halt = 1;
        step(10);
        check1("R1", "held while busy", frz_ack, 1'b0);
        busy_all = 0;
        step(2);
        check1("R1", "frozen", frz_ack, 1'b1);
        check1("R3", "counter write ok", ecnt_ok, 1'b1);
        check1("R2", "prescaler off", presc_en, 1'b0);
        // R4: exit freeze
        halt = 0;
        step(1);
        check1("R4", "freeze left", frz_ack, 1'b0);
        check1("R4", "still not ready", not_ready, 1'b1);
        // R5: dominant bit restarts the run
        step(20);
        rx = 0; step(8);
        rx = 1; step(30);
        check1("R5", "run restarted", not_ready, 1'b1);
        step(30);
        check1("R5", "run completed", not_ready, 1'b0);

        // R1: aborted freeze returns to active
        busy_all = 1; halt = 1;
        step(3);
        halt = 0;
        step(2);
        check1("R1", "abort keeps sync", not_ready, 1'b0);
        busy_all = 0;

        // R12: freeze beats stop
        frz_line = 1; stop = 1; bus_idle = 1;
        step(3);
        check1("R12", "freeze first", frz_ack, 1'b1);
        check1("R12", "no stop ack", stop_ack, 1'b0);
        // R6: stop handshake
        bus_idle = 0; gap3 = 0; busy_core = 1; frz_line = 0;
        step(6);
        check1("R6", "waiting for bus", stop_ack, 1'b0);
        gap3 = 1;
        step(4);
        check1("R6", "waiting for core", stop_ack, 1'b0);
        busy_core = 0;
        step(3);
        check1("R6", "stopped", stop_ack, 1'b1);
        check1("R7", "clock gated", clk_en, 1'b0);
        // R9 / R8: edge without self-wake
        rx = 0;
        step(2);
        check1("R9", "wake flag set", wake_flag, 1'b1);
        check1("R8", "no self-wake", stop_ack, 1'b1);
        wakemsk = 1; step(1);
        check1("R10", "irq unmasked", irq, 1'b1);
        wakemsk = 0; step(1);
        check1("R10", "irq masked", irq, 1'b0);
        rx = 1; wake_clr = 1; step(1);
        wake_clr = 0;
        check1("R9", "flag cleared", wake_flag, 1'b0);
        stop = 0;
        step(2);
        check1("R8", "stop cleared exit", stop_ack, 1'b0);
        check1("R8", "resync after stop", not_ready, 1'b1);
        gap3 = 0;
        step(60);

        // R8: self-wake
        bus_idle = 1; selfwake = 1; stop = 1;
        step(5);
        check1("R8", "stopped armed", stop_ack, 1'b1);
        selfwake = 0;
        rx = 0;
        step(1);
        check1("R8", "stop clear pulse", stop_clr, 1'b1);
        check1("R8", "woke up", stop_ack, 1'b0);
        stop = 0;
        step(1);
        check1("R8", "pulse single", stop_clr, 1'b0);
        rx = 1;
        step(60);
        check1("R5", "synced after wake", not_ready, 1'b0);

        // R11: soft reset
        halt = 1;
        step(4);
        check1("R11", "frozen before", frz_ack, 1'b1);
        softrst = 1; step(1);
        softrst = 0; halt = 0;
        check1("R11", "soft reset exit", frz_ack, 1'b0);
        check1("R11", "soft reset not ready", not_ready, 1'b1);
        step(60);

        // R12: freeze diverts a pending stop
        bus_idle = 0; gap3 = 0; stop = 1;
        step(3);
        frz_line = 1;
        step(3);
        check1("R12", "freeze diverts stop", frz_ack, 1'b1);
        frz_line = 0; stop = 0;
        step(60);
        check1("R5", "final sync", not_ready, 1'b0);

        summary();
        $finish;
    end

endmodule